// File: doc/BRIEF.md
# Fractional NCO Clock Generator Bank

This block holds four independent numerically controlled oscillators. Each one runs off the core clock. Each oscillator keeps a 32-bit phase accumulator and a 32-bit increment word N. The square-wave output averages a frequency of f_core × N / 2^32, so any fraction of the core clock up to one half can be produced without a divider chain.

Software, or a neighbouring control block, programs an oscillator with a single-cycle write. The write carries a 2-bit index and the new 32-bit increment. Writing zero parks that oscillator with its output held low. The four outputs go to whatever logic routes clocks to pins. Increments above 2^31−1 are not legal, and the block assumes they are never written.

Top module: `nco_clk_bank`

## Requirements
- R1: With a constant increment N on an oscillator, the number of rising edges of its output in any window of W core cycles is within one of W·N/2^32.
- R2: After reset, each output equals bit 31 of a 32-bit accumulator. The accumulator starts at 0 and gains that oscillator's current increment on every core clock edge, modulo 2^32.
- R3: If an oscillator's increment has been zero for at least two clock edges, its output is 0 and stays 0 until a nonzero increment is written.
- R4: A write takes effect on the clock edge that follows the write edge. Changing the increment between nonzero values does not clear the accumulator, so the phase carries on from its current value.
- R5: A write with index i (00, 01, 10 or 11 selects oscillator 0 to 3) changes only oscillator i. The other three keep their increments and their waveforms.
- R6: A synchronous reset clears every increment and every accumulator, so all outputs are 0 one edge after reset is sampled and stay 0 until a nonzero increment is written.
- R7: While the write strobe is low, the index and data inputs have no effect on any oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the increment registers |
| wr_idx | input | 2 | Oscillator selected by the write |
| wr_data | input | 32 | New increment N |
| clk_out | output | 4 | Generated clocks, bit i from oscillator i |

## Verification
A corrupted accumulator or increment shows up at the ports as a shifted or wrongly spaced edge on the affected output. The bench keeps its own arithmetic accumulator per oscillator and compares every output on every cycle, so such an error is reported within one cycle of reaching the accumulator's top bit. For small increments that bit may take many cycles to move, so the bench also counts edges over long windows. The windowed count exposes a wrong rate even when the phase happens to agree. A write that lands on the wrong index changes the waveform of a second oscillator, and the per-cycle comparison of all four outputs catches that.

// File: rtl/nco_clk_bank.sv
module nco_clk_bank #(
  parameter int NUM_GEN = 4,
  parameter int ACC_W   = 32,
  localparam int IDX_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ACC_W-1:0]   wr_data,
  output logic [NUM_GEN-1:0] clk_out
);

  logic [ACC_W-1:0] inc_q [NUM_GEN];
  logic [ACC_W-1:0] acc_q [NUM_GEN];

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    wire sel = wr_en && (wr_idx == IDX_W'(g));
    wire idle = (inc_q[g] == '0);

    always_ff @(posedge clk) begin
      if (rst)      inc_q[g] <= '0;
      else if (sel) inc_q[g] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst || idle) acc_q[g] <= '0;
      else             acc_q[g] <= acc_q[g] + inc_q[g];
    end

    assign clk_out[g] = acc_q[g][ACC_W-1];
  end

endmodule

// File: rtl/nco_clk_bank_chk.sv
module nco_clk_bank_chk #(
  parameter int NUM_GEN = 4,
  parameter int ACC_W   = 32,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [ACC_W-1:0]   wr_data,
  input logic [NUM_GEN-1:0] clk_out,
  input logic [ACC_W-1:0]   inc_q [NUM_GEN]
);

  logic [NUM_GEN-1:0] stopped;

  a_r6_reset_clears: assert property (@(posedge clk) $past(rst) |-> clk_out == '0);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    always_ff @(posedge clk) begin
      if (rst) stopped[g] <= 1'b1;
      else if (wr_en && wr_idx == IDX_W'(g)) stopped[g] <= (wr_data == '0);
    end

    a_r3_stopped_low: assert property (@(posedge clk) disable iff (rst)
      (stopped[g] && $past(stopped[g])) |-> !clk_out[g]);

    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IDX_W'(g)) |=> inc_q[g] == $past(wr_data));

    a_r5_other_inc_stable: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx != IDX_W'(g)) |=> $stable(inc_q[g]));

    a_r7_idle_no_change: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(inc_q[g]));
  end

endmodule

bind nco_clk_bank nco_clk_bank_chk #(
  .NUM_GEN(NUM_GEN), .ACC_W(ACC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .clk_out(clk_out), .inc_q(inc_q)
);

// File: tb/nco_clk_bank_bench.sv
`timescale 1ns/1ps
module nco_clk_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R2";

  logic [31:0] m_acc [4];
  logic [31:0] m_n [4];
  logic [3:0]  prev_out = '0;
  int          rises [4];

  always #2 clk = ~clk;

  nco_clk_bank u_nco_clk_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .clk_out(clk_out)
  );

  always @(posedge clk) begin
    for (int g = 0; g < 4; g++) begin
      if (rst) begin
        m_acc[g] = '0;
        m_n[g] = '0;
      end else begin
        m_acc[g] = (m_n[g] == 0) ? 32'd0 : m_acc[g] + m_n[g];
      end
    end
    if (!rst && wr_en) m_n[wr_idx] = wr_data;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int g = 0; g < 4; g++) begin
        checks++;
        if (clk_out[g] !== m_acc[g][31]) begin
          errors++;
          $display("FAIL %s gen%0d waveform: got %b expected %b", tag, g, clk_out[g], m_acc[g][31]);
        end
        if (clk_out[g] && !prev_out[g]) rises[g]++;
      end
    end
    prev_out = clk_out;
  end

  task automatic check(input string req, input longint got, input longint exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_rises();
    for (int g = 0; g < 4; g++) rises[g] = 0;
  endtask

  task automatic rate_check(input int g, input logic [31:0] n, input int w);
    longint exp;
    longint diff;
    exp = (longint'(w) * longint'(n)) >>> 32;
    diff = rises[g] - exp;
    checks++;
    if (diff > 1 || diff < -1) begin
      errors++;
      $display("FAIL R1 gen%0d N=%h rises: got %0d expected %0d", g, n, rises[g], exp);
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_rises();
    repeat (3) @(negedge clk);
    check("R6", clk_out, 0, "outputs during reset");
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R6", clk_out, 0, "outputs idle after reset");

    // single oscillators, several increments
    begin
      logic [31:0] ns [4];
      ns[0] = 32'h1000_0000; ns[1] = 32'h7FFF_FFFF; ns[2] = 32'h1234_5678; ns[3] = 32'h0010_0000;
      for (int g = 0; g < 4; g++) begin
        tag = "R1";
        wr(2'(g), ns[g]);
        @(negedge clk);
        clear_rises();
        repeat (8192) @(negedge clk);
        rate_check(g, ns[g], 8192);
        tag = "R3";
        wr(2'(g), 32'd0);
        repeat (50) @(negedge clk);
        check("R3", clk_out[g], 0, "stopped output");
      end
    end

    // all four at once with distinct rates
    tag = "R5";
    wr(2'd0, 32'h0800_0000);
    wr(2'd1, 32'h2000_0001);
    wr(2'd2, 32'h4000_0000);
    wr(2'd3, 32'h0003_0000);
    @(negedge clk);
    clear_rises();
    repeat (16384) @(negedge clk);
    rate_check(0, 32'h0800_0000, 16384);
    rate_check(1, 32'h2000_0001, 16384);
    rate_check(2, 32'h4000_0000, 16384);
    rate_check(3, 32'h0003_0000, 16384);

    // stop one, others continue
    wr(2'd2, 32'd0);
    clear_rises();
    repeat (4096) @(negedge clk);
    check("R5", rises[2], 0, "stopped gen2 rises");
    checks++;
    if (rises[0] == 0 || rises[1] == 0) begin
      errors++;
      $display("FAIL R5 neighbours stalled: got %0d/%0d expected nonzero", rises[0], rises[1]);
    end

    // rate change mid-phase keeps phase
    tag = "R4";
    wr(2'd1, 32'h4000_0000);
    repeat (3) @(negedge clk);
    wr(2'd1, 32'h1000_0000);
    repeat (40) @(negedge clk);
    wr(2'd1, 32'h5000_0000);
    repeat (40) @(negedge clk);

    // strobe low: inputs ignored
    tag = "R7";
    @(negedge clk);
    wr_idx = 2'd0; wr_data = 32'd0;
    repeat (10) begin
      @(negedge clk);
      wr_idx = wr_idx + 2'd1;
      wr_data = wr_data + 32'h0111_0000;
    end
    clear_rises();
    repeat (1024) @(negedge clk);
    rate_check(0, 32'h0800_0000, 1024);
    check("R7", rises[2], 0, "gen2 stays stopped");

    // reset mid-run
    tag = "R6";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6", clk_out, 0, "outputs after reset edge");
    rst = 1'b0;
    clear_rises();
    repeat (2000) @(negedge clk);
    check("R6", rises[0] + rises[1] + rises[3], 0, "rises after reset");

    // restart from zero
    tag = "R2";
    wr(2'd3, 32'h6000_0000);
    repeat (100) @(negedge clk);
    check("R2", m_n[3], 32'h6000_0000, "model increment");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule